// File: doc/BRIEF.md
# IDE Channel Port Access Decoder

This block sits between a host I/O bus and the task-file register interface of one disk channel. The host reaches the channel through two windows: an 8-byte command/data window and a 4-byte control window. Every request names its window, a byte offset inside that window and a transfer size of one, two or four bytes. The decoder decides whether the request is legal, remaps its offset into the task-file address space, and forwards it with a single-cycle read or write strobe. Illegal requests never reach the task file. An illegal read answers with all ones across the requested width. An illegal write is dropped without any effect.

In the control window, only a byte access at offset 2 is legal. It is forwarded to task-file control register 4, which reads as alternate status and writes as device control. In the data window, any byte access is forwarded at its own offset. A two- or four-byte access is forwarded as a data-port transfer, but only at offset 0.

The task file answers reads combinationally in the cycle of the strobe. The decoder registers the formatted read word and presents it one cycle after the request.

Top module: `ide_chan_decode`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is 0 and neither `tf_rd` nor `tf_wr` is asserted.
- R2: A control-window read (`acc_win`=1) of size code 0 (one byte) at offset 2 asserts `tf_rd` in the same cycle, with `tf_ctl_sel`=1, `tf_addr`=4 and `tf_size`=0. On the following cycle `rd_data` is `tf_rdata[7:0]` zero-extended.
- R3: A control-window write of size code 0 at offset 2 asserts `tf_wr` with `tf_ctl_sel`=1, `tf_addr`=4, and `tf_wdata` equal to `acc_wdata[7:0]` zero-extended.
- R4: A control-window read at any other offset (0..7), or with any other size code, asserts no strobe. Its `rd_data` is all ones in the requested width (0x000000FF, 0x0000FFFF or 0xFFFFFFFF for codes 0, 1, 2).
- R5: A control-window write that is not a one-byte access at offset 2 asserts no strobe.
- R6: A data-window access (`acc_win`=0) of size code 0 at any offset 0..7 is forwarded with `tf_ctl_sel`=0 and `tf_addr` equal to the offset. Reads return the low byte zero-extended; writes carry the low byte zero-extended.
- R7: A data-window access of size code 1 (two bytes) or code 2 (four bytes) at offset 0 is forwarded with `tf_addr`=0 and the same `tf_size`. Reads return the low 16 bits zero-extended or all 32 bits.
- R8: A data-window access of size code 1 or 2 at a nonzero offset asserts no strobe. A read returns all ones of the requested width.
- R9: `rd_valid` is 1 exactly in the cycle after a read request (`acc_valid`=1, `acc_write`=0) and 0 otherwise. `rd_data` holds its value when no read is made.
- R10: Size code 3 is illegal in both windows. It asserts no strobe, and a read returns 0xFFFFFFFF.
- R11: `tf_rd` and `tf_wr` are never asserted together, and neither is asserted while `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_win | input | 1 | 0 = data window, 1 = control window |
| acc_offset | input | 3 | Byte offset inside the window |
| acc_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| acc_wdata | input | 32 | Host write data |
| rd_data | output | 32 | Registered read response |
| rd_valid | output | 1 | Read response valid |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| tf_ctl_sel | output | 1 | Selects the control register group |
| tf_addr | output | 3 | Task-file register offset |
| tf_size | output | 2 | Forwarded size code |
| tf_wdata | output | 32 | Write data, zero-extended to the size |
| tf_rdata | input | 32 | Task-file read data, same cycle as `tf_rd` |

## Verification
The hardest cases to reach are back-to-back reads in which a legal read follows an illegal one. The registered response must switch between task-file data and all-ones padding with no residue from the cycle before. The stimulus therefore issues reads on consecutive cycles across every offset and size of both windows, with no idle cycle between them. A scoreboard queue pairs each response with its request. The downstream model returns data that depends on the address, so a remapping error shows up in the read value as well as at the strobe outputs.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_RSV = 2'd3
  } acc_size_e;

  // Byte lanes covered by a size code; reserved code spans the full word.
  function automatic logic [3:0] lane_mask(input logic [1:0] sz);
    logic [3:0] m;
    case (sz)
      2'd0:    m = 4'b0001;
      2'd1:    m = 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ide_legal_chk.sv
module ide_legal_chk #(
  parameter int OFS_W       = 3,
  parameter int CTL_WIN_LEN = 4,
  parameter int CTL_OFS     = 2,
  parameter int CTL_REMAP   = 4
) (
  input  logic             win_ctl,
  input  logic [OFS_W-1:0] offset,
  input  logic [1:0]       size,
  output logic             legal,
  output logic [OFS_W-1:0] fwd_addr
);
  import ide_dec_pkg::*;

  localparam logic [OFS_W-1:0] CTL_OFS_V   = OFS_W'(CTL_OFS);
  localparam logic [OFS_W-1:0] CTL_REMAP_V = OFS_W'(CTL_REMAP);

  logic is_byte;
  logic size_ok;
  logic ctl_ok;
  logic dat_ok;
  logic in_ctl_win;

  always_comb begin
    is_byte    = (size == SZ_B1);
    size_ok    = (size != SZ_RSV);
    in_ctl_win = (int'(offset) < CTL_WIN_LEN);
    ctl_ok     = in_ctl_win && is_byte && (offset == CTL_OFS_V);
    dat_ok     = size_ok && (is_byte || (offset == '0));
    legal      = win_ctl ? ctl_ok : dat_ok;
    fwd_addr   = win_ctl ? CTL_REMAP_V : offset;
  end
endmodule

// File: rtl/ide_rdata_fmt.sv
module ide_rdata_fmt #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              legal,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] tf_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  import ide_dec_pkg::*;

  localparam int LANES = DATA_W / 8;

  logic [3:0]        mask;
  logic [DATA_W-1:0] rd_data_nxt;
  logic              rd_valid_nxt;
  logic              legal_q;

  always_comb mask = lane_mask(size);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (!mask[g])
        rd_data_nxt[g*8 +: 8] = 8'h00;
      else if (legal)
        rd_data_nxt[g*8 +: 8] = tf_rdata[g*8 +: 8];
      else
        rd_data_nxt[g*8 +: 8] = 8'hFF;
    end
  end

  always_comb rd_valid_nxt = rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_valid_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      legal_q <= 1'b0;
    end else if (rd_req) begin
      rd_data <= rd_data_nxt;
      legal_q <= legal;
    end
  end

  AST_ILLEGAL_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !legal_q) |-> (rd_data[7:0] == 8'hFF)) else $error("illegal read not padded"); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_data)) else $error("rd_data changed without read"); // R9
endmodule

// File: rtl/ide_chan_decode.sv
module ide_chan_decode #(
  parameter int DATA_W       = 32,
  parameter int DATA_WIN_LEN = 8,
  parameter int CTL_WIN_LEN  = 4,
  parameter int CTL_OFS      = 2,
  parameter int CTL_REMAP    = 4,
  parameter int OFS_W        = $clog2(DATA_WIN_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_win,
  input  logic [OFS_W-1:0]  acc_offset,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic              tf_ctl_sel,
  output logic [OFS_W-1:0]  tf_addr,
  output logic [1:0]        tf_size,
  output logic [DATA_W-1:0] tf_wdata,
  input  logic [DATA_W-1:0] tf_rdata
);
  import ide_dec_pkg::*;

  localparam int LANES = DATA_W / 8;

  logic             legal;
  logic [OFS_W-1:0] fwd_addr;
  logic [3:0]       wmask;
  logic             rd_req;

  ide_legal_chk #(
    .OFS_W      (OFS_W),
    .CTL_WIN_LEN(CTL_WIN_LEN),
    .CTL_OFS    (CTL_OFS),
    .CTL_REMAP  (CTL_REMAP)
  ) i_legal (
    .win_ctl (acc_win),
    .offset  (acc_offset),
    .size    (acc_size),
    .legal   (legal),
    .fwd_addr(fwd_addr)
  );

  always_comb begin
    rd_req     = acc_valid && !acc_write;
    tf_rd      = rd_req && legal;
    tf_wr      = acc_valid && acc_write && legal;
    tf_ctl_sel = acc_win;
    tf_addr    = fwd_addr;
    tf_size    = acc_size;
    wmask      = lane_mask(acc_size);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_wlane
    always_comb tf_wdata[g*8 +: 8] = wmask[g] ? acc_wdata[g*8 +: 8] : 8'h00;
  end

  ide_rdata_fmt #(.DATA_W(DATA_W)) i_fmt (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (rd_req),
    .legal   (legal),
    .size    (acc_size),
    .tf_rdata(tf_rdata),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tf_rd && tf_wr)) else $error("both strobes"); // R11
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!tf_rd && !tf_wr)) else $error("strobe while idle"); // R11
  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid) else $error("missing rd_valid"); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rd_valid) else $error("spurious rd_valid"); // R9
  AST_CTL_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((tf_rd || tf_wr) && tf_ctl_sel) |-> (tf_addr == OFS_W'(CTL_REMAP) && tf_size == SZ_B1)) else $error("bad control remap"); // R2
  AST_WIDE_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((tf_rd || tf_wr) && tf_size != SZ_B1) |-> (tf_addr == '0 && !tf_ctl_sel)) else $error("wide access off base"); // R7
  AST_NO_RSV_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_rd || tf_wr) |-> (tf_size != SZ_RSV)) else $error("reserved size forwarded"); // R10
endmodule

// File: tb/test_ide_chan_decode.sv
module test_ide_chan_decode;
  logic        clk;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_write;
  logic        acc_win;
  logic [2:0]  acc_offset;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        tf_rd;
  logic        tf_wr;
  logic        tf_ctl_sel;
  logic [2:0]  tf_addr;
  logic [1:0]  tf_size;
  logic [31:0] tf_wdata;
  logic [31:0] tf_rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       req_q[$];
  bit          done = 0;

  ide_chan_decode i_ide_chan_decode (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_win(acc_win), .acc_offset(acc_offset), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_ctl_sel(tf_ctl_sel), .tf_addr(tf_addr),
    .tf_size(tf_size), .tf_wdata(tf_wdata), .tf_rdata(tf_rdata)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // Downstream task-file model: address-dependent read data.
  function automatic logic [31:0] tf_model(input logic ctl, input logic [2:0] a);
    return ctl ? 32'h7E6D_5C4B : (32'h8877_6650 + {29'b0, a});
  endfunction
  always_comb tf_rdata = tf_model(tf_ctl_sel, tf_addr);

  function automatic logic [31:0] width_mask(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic win, input logic wr, input logic [2:0] ofs,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input bit fwd, input string req);
    logic [31:0] m;
    logic [2:0]  ea;
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_win = win;
    acc_offset = ofs; acc_size = sz; acc_wdata = wd;
    m  = width_mask(sz);
    ea = win ? 3'd4 : ofs;
    if (!wr) begin
      exp_q.push_back(fwd ? (tf_model(win, ea) & m) : m);
      req_q.push_back(req);
    end
    #1;
    check(tf_rd == (fwd && !wr) && tf_wr == (fwd && wr), req, "strobes",
          {30'b0, tf_rd, tf_wr}, {30'b0, fwd && !wr, fwd && wr});
    if (fwd) begin
      check(tf_ctl_sel == win && tf_addr == ea && tf_size == sz, req, "fwd addr",
            {27'b0, tf_ctl_sel, tf_addr}, {27'b0, win, ea});
      if (wr) check(tf_wdata == (wd & m), req, "wdata", tf_wdata, wd & m);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 0;
  endtask

  // Monitor: pairs each registered response with the queued expectation.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R9", "unexpected rd_valid", 32'd1, 32'd0);
        end else begin
          logic [31:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(rd_data == e, r, "rd_data", rd_data, e);
        end
      end else if (exp_q.size() != 0) begin
        check(0, "R9", "rd_valid missing", 32'd0, 32'd1);
        void'(exp_q.pop_front());
        void'(req_q.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    check(0, "WDOG", "watchdog expired", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst_n = 0; acc_valid = 0; acc_write = 0; acc_win = 0;
    acc_offset = 0; acc_size = 0; acc_wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    check(rd_valid == 0 && rd_data == 0 && !tf_rd && !tf_wr, "R1", "reset state",
          rd_data, 32'd0);
    @(negedge clk);
    rst_n = 1;

    // Control window legal read/write
    access(1, 0, 3'd2, 2'd0, 32'h0, 1, "R2");
    access(1, 1, 3'd2, 2'd0, 32'hDEAD_BE3C, 1, "R3");
    // Control window illegal reads back to back, then legal read
    for (int o = 0; o < 8; o++)
      if (o != 2) access(1, 0, 3'(o), 2'd0, 32'h0, 0, "R4");
    access(1, 0, 3'd2, 2'd1, 32'h0, 0, "R4");
    access(1, 0, 3'd2, 2'd2, 32'h0, 0, "R4");
    access(1, 0, 3'd2, 2'd0, 32'h0, 1, "R2");
    // Control window illegal writes
    access(1, 1, 3'd0, 2'd0, 32'h11, 0, "R5");
    access(1, 1, 3'd6, 2'd0, 32'h22, 0, "R5");
    access(1, 1, 3'd2, 2'd2, 32'h33, 0, "R5");
    // Data window byte accesses at every offset
    for (int o = 0; o < 8; o++) access(0, 0, 3'(o), 2'd0, 32'h0, 1, "R6");
    for (int o = 0; o < 8; o++) access(0, 1, 3'(o), 2'd0, 32'hA5A5_A500 + o, 1, "R6");
    // Wide at base
    access(0, 0, 3'd0, 2'd1, 32'h0, 1, "R7");
    access(0, 0, 3'd0, 2'd2, 32'h0, 1, "R7");
    access(0, 1, 3'd0, 2'd1, 32'hCAFE_1234, 1, "R7");
    access(0, 1, 3'd0, 2'd2, 32'hCAFE_1234, 1, "R7");
    // Wide off base, interleaved with legal reads
    for (int o = 1; o < 8; o++) begin
      access(0, 0, 3'(o), 2'd1, 32'h0, 0, "R8");
      access(0, 0, 3'd0, 2'd2, 32'h0, 1, "R7");
      access(0, 0, 3'(o), 2'd2, 32'h0, 0, "R8");
      access(0, 1, 3'(o), 2'd2, 32'h5555_5555, 0, "R8");
    end
    // Reserved size in both windows
    access(0, 0, 3'd0, 2'd3, 32'h0, 0, "R10");
    access(1, 0, 3'd2, 2'd3, 32'h0, 0, "R10");
    access(0, 1, 3'd0, 2'd3, 32'h1, 0, "R10");
    // Hold of rd_data during idle and writes
    access(0, 0, 3'd3, 2'd0, 32'h0, 1, "R9");
    idle();
    #1;
    held = rd_data;
    idle();
    access(0, 1, 3'd0, 2'd2, 32'h0, 1, "R9");
    idle();
    #1;
    check(rd_data == held && !rd_valid, "R9", "hold without read", rd_data, held);
    check(!tf_rd && !tf_wr, "R11", "idle strobes", {30'b0, tf_rd, tf_wr}, 32'd0);
    repeat (3) idle();
    check(exp_q.size() == 0, "R9", "pending responses", exp_q.size(), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule